// File: doc/BRIEF.md
# Serial Peripheral Interrupt Controller

This block gathers the interrupt events of a serial port and turns them into four separate level-sensitive interrupt lines, one for each source: transmit threshold reached, receive threshold reached, transmit side drained and receive overrun. Each source sets a sticky pending bit when it pulses for one cycle. Software acknowledges a bit by writing a 1 to it, masks lines through a mask register, and can raise pending bits on purpose through a write-only injection register. This is useful for testing interrupt handlers without driving traffic.

Access is by whole 32-bit words on a simple write/read port. The read port is combinational. Each output line is registered. It goes high in the cycle after both its pending bit and its mask bit are set, and it follows every register write on the next clock.

Top module: `irq_status_top`

## Requirements
- R1: After reset all pending bits and all mask bits are 0, and all four interrupt lines are low.
- R2: The pending bit positions are fixed: bit 0 is transmit threshold, bit 1 is receive threshold, bit 2 is transmit drained and bit 3 is receive overrun. A one-cycle pulse on a source's event input sets its pending bit, and the bit stays set until it is cleared.
- R3: A write to offset 0x0 (pending) clears every pending bit written as 1. Pending bits written as 0 are left unchanged.
- R4: A write to offset 0x4 (mask) replaces the whole mask. Only bits 3:0 are stored.
- R5: A write to offset 0x8 (inject) ORs bits 3:0 of the written data into the pending bits. Reading offset 0x8 returns 0.
- R6: Each interrupt line is high exactly when its pending bit and its mask bit are both 1. The line updates one clock after the register state changes, and each line is independent of the others.
- R7: If an event pulse and a clear-write hit the same pending bit in the same cycle, the event wins and the bit stays set.
- R8: A write to any offset other than 0x0, 0x4 or 0x8 has no effect on the pending bits, the mask or the interrupt lines. Reading such an offset returns 0.
- R9: Reads of offset 0x0 return the pending bits and reads of offset 0x4 return the mask. Bits 31:4 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Word write strobe |
| wrAddr | input | 4 | Byte offset of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Byte offset of the read |
| rdData | output | 32 | Combinational read data |
| evtPulse | input | 4 | One-cycle event pulses, one per source (bit order as in R2) |
| irqOut | output | 4 | Per-source interrupt lines (bit order as in R2) |

## Verification
The assertions assume that the event inputs and the write port are driven synchronously and are never X once reset is released. They also assume that every access is a full word, since there is no byte-enable input. Checks on the lines compare against the pending and mask state of the previous cycle, so they need no assumption about how often events arrive. The stimulus drives all inputs half a period away from the rising edge, and it changes the write fields only while a strobe is issued.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned DataW   = 32;
  localparam int unsigned AddrW   = 4;
  localparam int unsigned NumSrc  = 4;

  localparam logic [AddrW-1:0] OffPending = 4'h0;
  localparam logic [AddrW-1:0] OffMask    = 4'h4;
  localparam logic [AddrW-1:0] OffInject  = 4'h8;

  typedef struct packed {
    logic                  clrStb;
    logic                  maskStb;
    logic                  injStb;
    logic [NumSrc-1:0]     wrBits;
  } regStrobe_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int unsigned AW  = AddrW,
  parameter int unsigned DW  = DataW,
  parameter int unsigned NS  = NumSrc
) (
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output regStrobe_t    strobe
);
  always_comb begin
    strobe         = '0;
    strobe.wrBits  = wrData[NS-1:0];
    if (wrEn) begin
      unique case (wrAddr)
        OffPending: strobe.clrStb  = 1'b1;
        OffMask:    strobe.maskStb = 1'b1;
        OffInject:  strobe.injStb  = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int unsigned AW = AddrW,
  parameter int unsigned DW = DataW,
  parameter int unsigned NS = NumSrc
) (
  input  logic          clk,
  input  logic          rstN,
  input  regStrobe_t    strobe,
  input  logic [NS-1:0] evtPulse,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic [NS-1:0] irqOut
);
  localparam int unsigned PadW = DW - NS;

  logic [NS-1:0] pendingQ;
  logic [NS-1:0] maskQ;
  logic [NS-1:0] pendingD;

  for (genvar g = 0; g < NS; g++) begin : gSrc
    always_comb begin
      pendingD[g] = pendingQ[g];
      if (strobe.clrStb && strobe.wrBits[g]) pendingD[g] = 1'b0;
      if (strobe.injStb && strobe.wrBits[g]) pendingD[g] = 1'b1;
      if (evtPulse[g])                       pendingD[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendingQ[g] <= 1'b0;
        maskQ[g]    <= 1'b0;
        irqOut[g]   <= 1'b0;
      end else begin
        pendingQ[g] <= pendingD[g];
        if (strobe.maskStb) maskQ[g] <= strobe.wrBits[g];
        irqOut[g]   <= pendingQ[g] & maskQ[g];
      end
    end
  end

  always_comb begin
    unique case (rdAddr)
      OffPending: rdData = {{PadW{1'b0}}, pendingQ};
      OffMask:    rdData = {{PadW{1'b0}}, maskQ};
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_top.sv
module irq_status_top
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AddrW-1:0]  wrAddr,
  input  logic [DataW-1:0]  wrData,
  input  logic [AddrW-1:0]  rdAddr,
  output logic [DataW-1:0]  rdData,
  input  logic [NumSrc-1:0] evtPulse,
  output logic [NumSrc-1:0] irqOut
);
  regStrobe_t strobe;

  irq_status_ctrl #(.AW(AddrW), .DW(DataW), .NS(NumSrc)) i_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobe (strobe)
  );

  irq_status_dp #(.AW(AddrW), .DW(DataW), .NS(NumSrc)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .evtPulse (evtPulse),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [AddrW-1:0]  wrAddr,
  input logic [DataW-1:0]  wrData,
  input logic [NumSrc-1:0] evtPulse,
  input logic [NumSrc-1:0] irqOut,
  input regStrobe_t        strobe,
  input logic [NumSrc-1:0] pendingQ,
  input logic [NumSrc-1:0] maskQ
);
  // R6: line follows previous pending & mask
  a_r6_line_tracks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == ($past(pendingQ) & $past(maskQ)));

  // R2: an event sets its pending bit
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse[0] |=> pendingQ[0]);

  // R7: event beats a simultaneous clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == OffPending && wrData[3] && evtPulse[3]) |=> pendingQ[3]);

  // R8: writes to unmapped offsets leave the state alone
  a_r8_unmapped: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != OffPending && wrAddr != OffMask && wrAddr != OffInject
     && evtPulse == '0) |=> ($stable(pendingQ) && $stable(maskQ)));

  // R4: the mask changes only on a mask write
  a_r4_mask_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == OffMask) |=> $stable(maskQ));

  // R3: a pending bit falls only because of a clear write
  a_r3_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendingQ[1]) |-> ($past(wrEn) && $past(wrAddr) == OffPending && $past(wrData[1])));

  // at most one strobe at a time
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrStb, strobe.maskStb, strobe.injStb}));
endmodule

bind irq_status_top irq_status_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .evtPulse (evtPulse),
  .irqOut   (irqOut),
  .strobe   (strobe),
  .pendingQ (i_dp.pendingQ),
  .maskQ    (i_dp.maskQ)
);

// File: tb/test_irq_status_top.sv
module test_irq_status_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [3:0]  evtPulse = '0;
  logic [3:0]  irqOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_status_top i_irq_status_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtPulse(evtPulse), .irqOut(irqOut)
  );

  // vector: {wrEn, addr, data[3:0], evt, expPending, expMask, expIrqAfter}
  typedef struct packed {
    logic       we;
    logic [3:0] addr;
    logic [3:0] data;
    logic [3:0] evt;
    logic [3:0] expPend;
    logic [3:0] expMask;
    logic [3:0] expIrq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h4, 4'hF, 4'h0, 4'h0, 4'hF, 4'h0}, // R4 mask all
    '{1'b0, 4'h0, 4'h0, 4'h1, 4'h1, 4'hF, 4'h0}, // R2 tx threshold event
    '{1'b0, 4'h0, 4'h0, 4'h8, 4'h9, 4'hF, 4'h1}, // R2 overrun event, R6
    '{1'b1, 4'h0, 4'h1, 4'h0, 4'h8, 4'hF, 4'h9}, // R3 clear bit0
    '{1'b1, 4'h8, 4'h6, 4'h0, 4'hE, 4'hF, 4'h8}, // R5 inject bits 1,2
    '{1'b1, 4'h4, 4'h2, 4'h0, 4'hE, 4'h2, 4'hE}, // R4 replace mask, R6
    '{1'b1, 4'hC, 4'hF, 4'h0, 4'hE, 4'h2, 4'h2}, // R8 unmapped write
    '{1'b1, 4'h0, 4'h8, 4'h8, 4'hE, 4'h2, 4'h2}, // R7 event beats clear
    '{1'b1, 4'h0, 4'hF, 4'h0, 4'h0, 4'h2, 4'h2}, // R3 clear all
    '{1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h2, 4'h0}  // R6 line drops
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  logic [31:0] rv;

  initial begin
    #20000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    readReg(4'h0, rv); check("R1 pending", rv, 32'h0);
    readReg(4'h4, rv); check("R1 mask", rv, 32'h0);
    check("R1 irq", {28'h0, irqOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wrEn = VECS[i].we; wrAddr = VECS[i].addr;
      wrData = {28'h0, VECS[i].data}; evtPulse = VECS[i].evt;
      @(negedge clk);
      wrEn = 1'b0; evtPulse = '0;
      readReg(4'h0, rv); check($sformatf("R2/R3 vec%0d pending", i), rv, {28'h0, VECS[i].expPend});
      readReg(4'h4, rv); check($sformatf("R4 vec%0d mask", i), rv, {28'h0, VECS[i].expMask});
      // irq reflects state before this edge's update
      check($sformatf("R6 vec%0d irq", i), {28'h0, irqOut}, {28'h0, VECS[i].expIrq});
    end

    // R5 inject register reads 0, R9 upper bits zero
    wrEn = 1'b1; wrAddr = 4'h4; wrData = 32'hFFFF_FFFF;
    @(negedge clk); wrEn = 1'b0;
    readReg(4'h4, rv); check("R9 mask upper zero", rv, 32'hF);
    readReg(4'h8, rv); check("R5 inject reads zero", rv, 32'h0);
    readReg(4'hC, rv); check("R8 unmapped reads zero", rv, 32'h0);

    // R6 independence: inject only rx threshold
    wrEn = 1'b1; wrAddr = 4'h8; wrData = 32'h2;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
    check("R6 single line", {28'h0, irqOut}, 32'h2);
    // R8 unmapped write with bits set must not clear
    wrEn = 1'b1; wrAddr = 4'h2; wrData = 32'hF;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
    check("R8 no effect irq", {28'h0, irqOut}, 32'h2);
    readReg(4'h0, rv); check("R8 no effect pending", rv, 32'h2);

    // R1 reset again clears everything
    rstN = 1'b0; #1;
    readReg(4'h0, rv); check("R1 reset pending", rv, 32'h0);
    check("R1 reset irq", {28'h0, irqOut}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule